// File: doc/BRIEF.md
# Parallel Leaky Integrate-and-Fire Neuron Bank

This block holds a bank of leaky integrate-and-fire neurons that advance together, one time step per spike-arrival event. When a strobe announces a new presynaptic spike vector, the block latches it. It then walks through the set bits from the lowest index upward, one per cycle. For each set bit it reads one row of signed 8-bit weights from an external synchronous synapse memory. Each row carries one weight per neuron, and every neuron that is not refractory adds its weight to its membrane potential.

Once every active input has been folded in, all neurons update in a single cycle. Each subtracts its leak, clamps the result at zero and compares it with the threshold. A neuron whose result is above the threshold fires, returns to zero and is then deaf to weights for a programmable number of steps. The new spike vector is published together with a one-cycle done pulse. The control is a three-state machine. ST_IDLE goes to ST_FETCH on an arrival. ST_FETCH stays in ST_FETCH while bits remain pending or a read is in flight, and goes to ST_FIRE once both are clear. ST_FIRE always returns to ST_IDLE.

Top module: `lif_array`

## Requirements
- R1: After reset `spk_out` is all zero, `done` is low and every potential and refractory count is zero.
- R2: The block leaves ST_IDLE only on `arrive`. An `arrive` seen while a step is in progress is ignored and does not change that step's reads or its result.
- R3: Reads are issued only for set bits of the latched vector, one per cycle, in ascending index order. `rd_addr` is the input index, `rd_en` is high for the first K cycles after the arrival edge (K = number of set bits), and the row is expected one cycle after the read.
- R4: Neuron j takes its weight from `rd_row[8*j+7:8*j]`, read as two's complement. Its potential becomes the old potential plus the sum of the weights of all active inputs.
- R5: The leak is subtracted once, after all of the step's weights are summed. A result below zero becomes zero.
- R6: A neuron fires only when its leaked potential is strictly greater than `thresh`. Firing sets its bit in `spk_out` to 1 and its potential to 0, and several neurons may fire in the same step.
- R7: After a fire the neuron ignores weights and does not fire for the next `refr_len` steps. It integrates again in the step after that, and `refr_len` = 0 means no blocking.
- R8: Each weight addition saturates at the signed potential limits rather than wrapping.
- R9: `done` is a single-cycle pulse. It rises 3 cycles after the arrival edge when K = 0 and K+4 cycles after it otherwise. `spk_out` changes only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arrive | input | 1 | Spike-arrival strobe |
| spikes_in | input | N_IN | Presynaptic spike vector, latched on arrival |
| rd_en | output | 1 | Weight-row read request |
| rd_addr | output | A_BITS | Index of the input whose row is read |
| rd_row | input | N_NEU*W_BITS | Weight row returned one cycle after the read |
| thresh | input | V_BITS-1 | Firing threshold (unsigned) |
| leak | input | V_BITS-1 | Leak subtracted each step (unsigned) |
| refr_len | input | R_BITS | Refractory length in steps |
| spk_out | output | N_NEU | Output spike vector, one bit per neuron |
| done | output | 1 | One-cycle pulse when `spk_out` is new |

## Verification
Two functions can fall in the same cycle. The first case is a spike-arrival strobe landing while ST_FETCH is still issuing reads. The bench provokes it by pulsing `arrive` with the inverted vector in the second cycle of a step. It then judges, cycle by cycle, that the read addresses, the done timing and the resulting spike vector match a step that saw no such strobe. The second case is a neuron leaving its refractory window in the same step that a strong weight reaches it. The reference model, written with plain integers, predicts the exact step in which the neuron fires again, and every clock's `done`, `rd_en`, `rd_addr` and `spk_out` are compared against it.

// File: rtl/lif_pkg.sv
package lif_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_FIRE  = 2'd2
    } lif_state_e;

endpackage

// File: rtl/lif_pick.sv
module lif_pick #(
    parameter int N      = 16,
    parameter int A_BITS = 4
) (
    input  logic [N-1:0]      req,
    output logic [N-1:0]      onehot,
    output logic [A_BITS-1:0] idx,
    output logic              any
);

    always_comb begin
        onehot = req & (~req + N'(1));
        any    = |req;
        idx    = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot[i]) begin
                idx = idx | A_BITS'(i);
            end
        end
    end

endmodule

// File: rtl/lif_ctrl.sv
module lif_ctrl
    import lif_pkg::*;
#(
    parameter int N_IN   = 16,
    parameter int A_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arrive,
    input  logic [N_IN-1:0]   spikes_in,
    output logic              rd_en,
    output logic [A_BITS-1:0] rd_addr,
    output logic              acc_en,
    output logic              upd_en,
    output logic              done,
    output logic              busy
);

    lif_state_e        state_q, state_d;
    logic [N_IN-1:0]   pend_q;
    logic              vld_q;
    logic              done_q;
    logic [N_IN-1:0]   pick_oh;
    logic [A_BITS-1:0] pick_idx;
    logic              pick_any;

    lif_pick #(.N(N_IN), .A_BITS(A_BITS)) u_pick (
        .req    (pend_q),
        .onehot (pick_oh),
        .idx    (pick_idx),
        .any    (pick_any)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        rd_en   = 1'b0;
        upd_en  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (arrive) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                rd_en = pick_any;
                if (!pick_any && !vld_q) state_d = ST_FIRE;
            end
            ST_FIRE: begin
                upd_en  = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Pending inputs, read-valid and done registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            vld_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && arrive) begin
                pend_q <= spikes_in;
            end else if (rd_en) begin
                pend_q <= pend_q & ~pick_oh;
            end
            vld_q  <= rd_en;
            done_q <= (state_q == ST_FIRE);
        end
    end

    assign rd_addr = pick_idx;
    assign acc_en  = vld_q;
    assign done    = done_q;
    assign busy    = (state_q != ST_IDLE);

endmodule

// File: rtl/lif_cell.sv
module lif_cell #(
    parameter int W_BITS = 8,
    parameter int V_BITS = 12,
    parameter int R_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              upd_en,
    input  logic [W_BITS-1:0] w,
    input  logic [V_BITS-2:0] thresh,
    input  logic [V_BITS-2:0] leak,
    input  logic [R_BITS-1:0] refr_len,
    output logic              spk,
    output logic              pot_nz,
    output logic              pot_neg,
    output logic              refr_busy
);

    localparam logic signed [V_BITS:0] VMAX = {2'b00, {(V_BITS-1){1'b1}}};
    localparam logic signed [V_BITS:0] VMIN = {2'b11, {(V_BITS-1){1'b0}}};

    logic signed [V_BITS-1:0] v_q;
    logic [R_BITS-1:0]        r_q;
    logic                     spk_q;
    logic signed [V_BITS:0]   sum;
    logic signed [V_BITS-1:0] sum_sat;
    logic signed [V_BITS:0]   lk;
    logic [V_BITS-1:0]        lk_cl;
    logic                     fire;

    always_comb begin
        sum = $signed({v_q[V_BITS-1], v_q})
            + $signed({{(V_BITS+1-W_BITS){w[W_BITS-1]}}, w});
        if (sum > VMAX)      sum_sat = VMAX[V_BITS-1:0];
        else if (sum < VMIN) sum_sat = VMIN[V_BITS-1:0];
        else                 sum_sat = sum[V_BITS-1:0];

        lk    = $signed({v_q[V_BITS-1], v_q}) - $signed({2'b00, leak});
        lk_cl = lk[V_BITS] ? '0 : lk[V_BITS-1:0];
        fire  = lk_cl > {1'b0, thresh};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q   <= '0;
            r_q   <= '0;
            spk_q <= 1'b0;
        end else if (acc_en) begin
            if (r_q == '0) v_q <= sum_sat;
        end else if (upd_en) begin
            if (r_q != '0) begin
                r_q   <= r_q - R_BITS'(1);
                spk_q <= 1'b0;
            end else if (fire) begin
                v_q   <= '0;
                r_q   <= refr_len;
                spk_q <= 1'b1;
            end else begin
                v_q   <= lk_cl;
                spk_q <= 1'b0;
            end
        end
    end

    assign spk       = spk_q;
    assign pot_nz    = (v_q != '0);
    assign pot_neg   = v_q[V_BITS-1];
    assign refr_busy = (r_q != '0);

endmodule

// File: rtl/lif_array.sv
module lif_array #(
    parameter int N_NEU  = 16,
    parameter int N_IN   = 16,
    parameter int W_BITS = 8,
    parameter int V_BITS = 12,
    parameter int R_BITS = 4,
    localparam int A_BITS = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    arrive,
    input  logic [N_IN-1:0]         spikes_in,
    output logic                    rd_en,
    output logic [A_BITS-1:0]       rd_addr,
    input  logic [N_NEU*W_BITS-1:0] rd_row,
    input  logic [V_BITS-2:0]       thresh,
    input  logic [V_BITS-2:0]       leak,
    input  logic [R_BITS-1:0]       refr_len,
    output logic [N_NEU-1:0]        spk_out,
    output logic                    done
);

    logic             acc_en;
    logic             upd_en;
    logic             busy;
    logic [N_NEU-1:0] pot_nz;
    logic [N_NEU-1:0] pot_neg;
    logic [N_NEU-1:0] refr_busy;

    lif_ctrl #(.N_IN(N_IN), .A_BITS(A_BITS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .arrive    (arrive),
        .spikes_in (spikes_in),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .acc_en    (acc_en),
        .upd_en    (upd_en),
        .done      (done),
        .busy      (busy)
    );

    for (genvar g = 0; g < N_NEU; g++) begin : g_neu
        lif_cell #(.W_BITS(W_BITS), .V_BITS(V_BITS), .R_BITS(R_BITS)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .acc_en    (acc_en),
            .upd_en    (upd_en),
            .w         (rd_row[g*W_BITS +: W_BITS]),
            .thresh    (thresh),
            .leak      (leak),
            .refr_len  (refr_len),
            .spk       (spk_out[g]),
            .pot_nz    (pot_nz[g]),
            .pot_neg   (pot_neg[g]),
            .refr_busy (refr_busy[g])
        );
    end

endmodule

// File: rtl/lif_array_chk.sv
module lif_array_chk #(
    parameter int N_NEU  = 16,
    parameter int A_BITS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              rd_en,
    input logic [A_BITS-1:0] rd_addr,
    input logic              done,
    input logic [N_NEU-1:0]  spk_out,
    input logic [N_NEU-1:0]  pot_nz,
    input logic [N_NEU-1:0]  pot_neg,
    input logic [N_NEU-1:0]  refr_busy
);

    p_idle_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_en);

    p_read_ascending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_addr > $past(rd_addr)));

    p_clamp_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pot_neg == '0));

    p_fire_resets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((spk_out & pot_nz) == '0));

    p_refr_holds_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (refr_busy & pot_nz) == '0);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_spk_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(spk_out));

endmodule

bind lif_array lif_array_chk #(.N_NEU(N_NEU), .A_BITS(A_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .done      (done),
    .spk_out   (spk_out),
    .pot_nz    (pot_nz),
    .pot_neg   (pot_neg),
    .refr_busy (refr_busy)
);

// File: tb/tb_lif_array.sv
`timescale 1ns/1ps
module tb_lif_array;

    localparam int N  = 16;
    localparam int V  = 12;
    localparam int VMX = 2047;
    localparam int VMN = -2048;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           arrive = 1'b0;
    logic [N-1:0]   spikes_in = '0;
    logic           rd_en;
    logic [3:0]     rd_addr;
    logic [N*8-1:0] row_q;
    logic [V-2:0]   thresh = '0;
    logic [V-2:0]   leak = '0;
    logic [3:0]     refr_len = '0;
    logic [N-1:0]   spk_out;
    logic           done;

    int n_tests = 0;
    int n_fail  = 0;
    logic signed [7:0] wmem [N][N];
    int mv [N];
    int mr [N];
    logic [N-1:0] prev_es;

    always #2.5 clk = ~clk;

    lif_array dut (
        .clk(clk), .rst_n(rst_n), .arrive(arrive), .spikes_in(spikes_in),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_row(row_q),
        .thresh(thresh), .leak(leak), .refr_len(refr_len),
        .spk_out(spk_out), .done(done)
    );

    // Synchronous synapse memory: row valid the cycle after the read
    always_ff @(posedge clk) begin
        if (rd_en) begin
            for (int j = 0; j < N; j++) row_q[j*8 +: 8] <= wmem[rd_addr][j];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int sat(input int x);
        if (x > VMX) return VMX;
        if (x < VMN) return VMN;
        return x;
    endfunction

    task automatic do_reset();
        arrive = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int j = 0; j < N; j++) begin mv[j] = 0; mr[j] = 0; end
        prev_es = '0;
        @(negedge clk);
        chk(spk_out == '0, "R1", "spk_out after reset", spk_out, 0);
        chk(done == 1'b0, "R1", "done after reset", done, 0);
    endtask

    task automatic set_pattern();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                wmem[i][j] = 8'(((i*7 + j*13) % 40) - 8);
    endtask

    task automatic set_all(input int w);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                wmem[i][j] = 8'(w);
    endtask

    task automatic do_step(input logic [N-1:0] s, input bit poke, input string req);
        logic [N-1:0] es;
        int q[$];
        int k, lat, x;
        for (int i = 0; i < N; i++) if (s[i]) q.push_back(i);
        k = q.size();
        lat = (k == 0) ? 3 : k + 4;
        for (int j = 0; j < N; j++) begin
            if (mr[j] > 0) begin
                mr[j]--;
                es[j] = 1'b0;
            end else begin
                x = mv[j];
                for (int i = 0; i < N; i++) if (s[i]) x = sat(x + int'(wmem[i][j]));
                x = x - int'(leak);
                if (x < 0) x = 0;
                if (x > int'(thresh)) begin
                    es[j] = 1'b1; x = 0; mr[j] = int'(refr_len);
                end else begin
                    es[j] = 1'b0;
                end
                mv[j] = x;
            end
        end
        @(negedge clk);
        arrive = 1'b1; spikes_in = s;
        @(negedge clk);
        arrive = 1'b0; spikes_in = '0;
        for (int e = 1; e <= lat + 1; e++) begin
            if (e > 1) @(negedge clk);
            chk(rd_en == (e <= k), "R3", "rd_en", rd_en, (e <= k));
            if (e <= k) chk(rd_addr == 4'(q[e-1]), "R3", "rd_addr", rd_addr, q[e-1]);
            chk(done == (e == lat), "R9", "done timing", done, (e == lat));
            if (e >= lat) chk(spk_out == es, req, "spk_out", spk_out, es);
            else          chk(spk_out == prev_es, "R9", "spk_out hold", spk_out, prev_es);
            if (poke && e == 2) begin arrive = 1'b1; spikes_in = ~s; end
            else begin arrive = 1'b0; spikes_in = '0; end
        end
        arrive = 1'b0;
        prev_es = es;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int lcg;
        set_pattern();
        // R1 reset, R4 mixed accumulation with refractory and leak
        thresh = 11'd100; leak = 11'd5; refr_len = 4'd2;
        do_reset();
        lcg = 12345;
        for (int t = 0; t < 24; t++) begin
            lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
            do_step(16'(lcg >> 8), 1'b0, "R4");
        end
        // R5 empty step: leak only
        do_step('0, 1'b0, "R5");
        do_step('0, 1'b0, "R5");

        // R5 clamp after negative sum, R6 strict threshold and multi-fire
        do_reset();
        thresh = 11'd100; leak = 11'd5; refr_len = 4'd0;
        set_all(0);
        for (int j = 0; j < N; j++) begin
            wmem[0][j] = -8'sd100;
            wmem[1][j] = (j % 2 == 0) ? 8'sd105 : 8'sd106;
        end
        do_step(16'h0001, 1'b0, "R5");
        do_step(16'h0002, 1'b0, "R6");
        do_step(16'h0000, 1'b0, "R5");

        // R7 refractory window of 3 steps
        do_reset();
        thresh = 11'd100; leak = 11'd0; refr_len = 4'd3;
        set_all(0);
        for (int j = 0; j < N; j++) wmem[2][j] = 8'sd127;
        for (int t = 0; t < 6; t++) do_step(16'h0004, 1'b0, "R7");
        // R7 zero-length refractory: fires every step
        do_reset();
        refr_len = 4'd0;
        for (int t = 0; t < 3; t++) do_step(16'h0004, 1'b0, "R7");

        // R8 saturation at the positive limit
        do_reset();
        thresh = 11'd2046; leak = 11'd0; refr_len = 4'd0;
        set_all(127);
        do_step(16'hFFFF, 1'b0, "R8");
        do_step(16'hFFFF, 1'b0, "R8");

        // R2 arrival during a step is ignored
        do_reset();
        set_pattern();
        thresh = 11'd60; leak = 11'd3; refr_len = 4'd1;
        do_step(16'h00F1, 1'b1, "R2");
        do_step(16'h8102, 1'b1, "R2");
        do_step(16'h0000, 1'b1, "R2");
        do_step(16'h3C3C, 1'b1, "R2");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule